// File: doc/BRIEF.md
# Patterned Destination Address Screen

This block screens the destination field of an incoming Ethernet frame while the frame is still arriving, one assembled byte at a time. It holds no station address. The expected value of each of the first six bytes is computed from that byte's position in the frame. Any byte may also be the all-ones broadcast value. The per-byte results are ANDed into a running accept flag. When the sixth byte has been judged, the block latches a keep or drop decision, so the receive path can abandon a frame meant for another station.

Frame framing comes from a select input. While select is inactive, the block rests in its idle state. Each received byte arrives with a one-cycle strobe and the low bits of the receive byte counter. The drop request stays asserted until select is released, and the next frame starts clean.

Top module: `pattern_mac_filter`

## Requirements
- R1: After reset, `accept` is 1 and `drop_req` is 0.
- R2: A byte at index i (0 to 5) matches the station pattern when bit 0 is 0, bit 1 is 1, bits 7:5 are all 1 and bits 4:2 equal the bitwise inverse of i. The full station address, first byte at index 0, is FE:FA:F6:F2:EE:EA. Such a frame keeps `accept` at 1 and never raises `drop_req`.
- R3: A destination of FF:FF:FF:FF:FF:FF is accepted in the same way.
- R4: The choice between the station pattern and broadcast is made separately for each byte, so a mixed field such as FE:FF:F6:FF:EE:FF is accepted.
- R5: A strobed byte in the window that fits neither choice clears `accept` one cycle after its strobe. `accept` stays 0 for the rest of the frame.
- R6: Bits 1 and 7:5 must be 1 in every byte. A byte with bit 0 set and bits 4:2 all ones still fails if any of those bits is 0 (for example 0xFD or 0x1F).
- R7: `drop_req` rises in the cycle after the strobe of the byte at index 5 when the accumulated result, including that byte, is a fail. It then stays high while select remains active.
- R8: Once the index-5 byte is judged, later strobes have no effect on `accept` or `drop_req`. This includes indices 6 and 7 and indices that wrap back to 0.
- R9: One cycle after `frame_sel` is low, `accept` is 1 and `drop_req` is 0, even in the middle of a frame.
- R10: Strobes while `frame_sel` is low are ignored.
- R11: `drop_req` stays 0 before the index-5 byte has been judged, even when `accept` is already 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sel | input | 1 | High while a frame is being received |
| rx_byte | input | DATA_W | Byte just assembled from the line |
| rx_stb | input | 1 | One-cycle strobe marking rx_byte as valid |
| rx_idx | input | IDX_W | Low bits of the received-byte counter for rx_byte |
| accept | output | 1 | Running accept flag for the destination field |
| drop_req | output | 1 | Registered request to abandon the current frame |

## Verification
The bench builds the block with its default values: 8-bit bytes, a 3-bit index and a six-byte window. With a 3-bit index, the counter can present indices 6 and 7 and then wrap to 0 and 1 after the decision is latched. This shows that the latched decision, not the index value alone, stops later bytes from counting. The same settings make every station-pattern byte differ from broadcast only in bit 0 and the inverted index field. Each failing byte used by the bench can therefore be chosen to break exactly one of those fields.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    // Filter state carried from one cycle to the next
    typedef struct packed {
        logic flag;  // running AND of the per-byte results
        logic done;  // decision for this frame has been taken
        logic drop;  // registered drop request
    } pmf_state_t;

    localparam pmf_state_t PMF_IDLE = '{flag: 1'b1, done: 1'b0, drop: 1'b0};

endpackage

// File: rtl/pmf_byte_check.sv
module pmf_byte_check #(
    parameter int DATA_W    = 8,
    parameter int IDX_W     = 3,
    parameter int FIELD_LSB = 2
) (
    input  logic [DATA_W-1:0] byte_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              byte_ok_o
);
    localparam int FIELD_MSB = FIELD_LSB + IDX_W - 1;
    localparam int CHOICE_BIT = 0;

    logic [DATA_W-1:0] fixed_mask_d;
    logic [IDX_W-1:0]  field_d;
    logic              fixed_ok_d;
    logic              own_hit_d;
    logic              bcast_hit_d;

    // Bits that must read one whichever address the byte belongs to
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        if (b == CHOICE_BIT || (b >= FIELD_LSB && b <= FIELD_MSB)) begin : g_var
            assign fixed_mask_d[b] = 1'b0;
        end else begin : g_fix
            assign fixed_mask_d[b] = 1'b1;
        end
    end

    always_comb begin
        field_d     = byte_i[FIELD_MSB:FIELD_LSB];
        fixed_ok_d  = &(byte_i | ~fixed_mask_d);
        own_hit_d   = !byte_i[CHOICE_BIT] && (field_d == ~idx_i);
        bcast_hit_d = byte_i[CHOICE_BIT] && (&field_d);
        byte_ok_o   = fixed_ok_d && (own_hit_d || bcast_hit_d);
    end

    // R6: a byte with a cleared always-one bit can never pass
    always_comb begin
        if (!fixed_ok_d) begin
            a_r6_fixed_bits: assert (!byte_ok_o)
                else $error("byte passed with a cleared fixed bit");
        end
    end

endmodule

// File: rtl/pmf_accum.sv
module pmf_accum
    import pmf_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int ADDR_BYTES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             stb_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             byte_ok_i,
    output logic             flag_o,
    output logic             drop_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);

    pmf_state_t st_d, st_q;
    logic       in_win_d;
    logic       merged_d;

    always_comb begin
        st_d     = st_q;
        in_win_d = int'(idx_i) < ADDR_BYTES;
        merged_d = st_q.flag & byte_ok_i;
        if (!sel_i) begin
            st_d = PMF_IDLE;
        end else if (stb_i && !st_q.done && in_win_d) begin
            st_d.flag = merged_d;
            if (idx_i == LAST_IDX) begin
                st_d.done = 1'b1;
                st_d.drop = !merged_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PMF_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign drop_o = st_q.drop;

    // R9: idle select restores the accept flag and clears the request
    a_r9_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> st_q.flag);
    a_r9_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_i |=> !st_q.drop);
    // R5: a cleared flag stays cleared while the frame continues
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !st_q.flag) |=> !st_q.flag);
    // R7: a new drop request only follows a strobe of the last window byte
    a_r7_drop_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drop && !$past(st_q.drop)) |-> $past(sel_i && stb_i && idx_i == LAST_IDX));
    // R8: the request holds for the rest of the frame
    a_r8_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && st_q.drop) |=> st_q.drop);
    // R11: no request before the decision is taken
    a_r11_drop_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drop |-> st_q.done);

endmodule

// File: rtl/pattern_mac_filter.sv
module pattern_mac_filter #(
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 3,
    parameter int ADDR_BYTES = 6,
    parameter int FIELD_LSB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sel,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_stb,
    input  logic [IDX_W-1:0]  rx_idx,
    output logic              accept,
    output logic              drop_req
);
    logic byte_ok;

    pmf_byte_check #(
        .DATA_W   (DATA_W),
        .IDX_W    (IDX_W),
        .FIELD_LSB(FIELD_LSB)
    ) u_check (
        .byte_i   (rx_byte),
        .idx_i    (rx_idx),
        .byte_ok_o(byte_ok)
    );

    pmf_accum #(
        .IDX_W     (IDX_W),
        .ADDR_BYTES(ADDR_BYTES)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (frame_sel),
        .stb_i    (rx_stb),
        .idx_i    (rx_idx),
        .byte_ok_i(byte_ok),
        .flag_o   (accept),
        .drop_o   (drop_req)
    );

endmodule

// File: tb/pattern_mac_filter_bench.sv
module pattern_mac_filter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sel = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_stb = 1'b0;
    logic [2:0] rx_idx = 3'd0;
    logic       accept;
    logic       drop_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  acc;
        logic  drp;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // Reference state kept from the requirements
    logic m_flag = 1'b1;
    logic m_done = 1'b0;
    logic m_drop = 1'b0;

    always #4 clk = ~clk;

    pattern_mac_filter u_pattern_mac_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_sel(frame_sel),
        .rx_byte  (rx_byte),
        .rx_stb   (rx_stb),
        .rx_idx   (rx_idx),
        .accept   (accept),
        .drop_req (drop_req)
    );

    function automatic logic ref_ok(logic [7:0] b, logic [2:0] i);
        logic [7:0] own;
        own = {3'b111, ~i, 2'b10};
        return (b == own) || (b == 8'hFF);
    endfunction

    task automatic compare(string tag, logic a_act, logic d_act, logic a_exp, logic d_exp);
        checks++;
        if (a_act !== a_exp || d_act !== d_exp) begin
            errors++;
            $display("FAIL %s: accept=%b drop_req=%b expected accept=%b drop_req=%b",
                     tag, a_act, d_act, a_exp, d_exp);
        end
    endtask

    // Driver: one cycle of stimulus plus its expected result
    task automatic drive(logic sel, logic stb, logic [2:0] idx, logic [7:0] b, string tag);
        exp_t e;
        @(negedge clk);
        frame_sel = sel;
        rx_stb    = stb;
        rx_idx    = idx;
        rx_byte   = b;
        if (!sel) begin
            m_flag = 1'b1;
            m_done = 1'b0;
            m_drop = 1'b0;
        end else if (stb && !m_done && idx < 3'd6) begin
            m_flag = m_flag & ref_ok(b, idx);
            if (idx == 3'd5) begin
                m_done = 1'b1;
                m_drop = !m_flag;
            end
        end
        e.acc = m_flag;
        e.drp = m_drop;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Six address bytes, first at index 0, with an idle cycle after each
    task automatic send_addr(logic [47:0] addr, string tag);
        for (int k = 0; k < 6; k++) begin
            drive(1'b1, 1'b1, 3'(k), addr[47 - 8*k -: 8], tag);
            drive(1'b1, 1'b0, 3'(k), 8'h00, tag);
        end
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 3'd0, 8'h00, tag);
    endtask

    // Monitor: pops one expectation per clock after the registers settle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                compare(e.tag, accept, drop_req, e.acc, e.drp);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 reset state", accept, drop_req, 1'b1, 1'b0);

        // R10: bad bytes while select is low change nothing
        drive(1'b0, 1'b1, 3'd0, 8'h00, "R10 strobe idle");
        drive(1'b0, 1'b1, 3'd5, 8'h13, "R10 strobe idle last");

        // R2: own station address, then R8: later indices incl. wrap
        drive(1'b1, 1'b0, 3'd0, 8'h00, "R2 open");
        send_addr(48'hFE_FA_F6_F2_EE_EA, "R2 own address");
        drive(1'b1, 1'b1, 3'd6, 8'h00, "R8 index 6");
        drive(1'b1, 1'b1, 3'd7, 8'h12, "R8 index 7");
        drive(1'b1, 1'b1, 3'd0, 8'h00, "R8 wrapped index 0");
        drive(1'b1, 1'b1, 3'd5, 8'h00, "R8 wrapped index 5");
        idle(2, "R9 close");

        // R3 broadcast
        send_addr(48'hFF_FF_FF_FF_FF_FF, "R3 broadcast");
        idle(1, "R9 close");

        // R4 mixed per-byte choice
        send_addr(48'hFE_FF_F6_FF_EE_FF, "R4 mixed");
        idle(1, "R9 close");
        send_addr(48'hFF_FA_FF_F2_FF_EA, "R4 mixed alt");
        idle(1, "R9 close");

        // R5 and R11: mismatch at index 2, R7 drop after index 5, R8 hold
        send_addr(48'hFE_FA_F7_F2_EE_EA, "R5 R11 R7 mismatch mid");
        drive(1'b1, 1'b1, 3'd6, 8'hFE, "R8 drop held");
        drive(1'b1, 1'b1, 3'd0, 8'hFE, "R8 drop held wrap");
        idle(1, "R9 clear drop");
        idle(1, "R9 stays idle");

        // R6: bit1 clear, and bits 7:5 clear on the last byte only
        send_addr(48'hFD_FA_F6_F2_EE_EA, "R6 bit1 clear");
        idle(1, "R9 close");
        send_addr(48'hFE_FA_F6_F2_EE_1F, "R6 R7 top bits clear last");
        idle(1, "R9 close");
        send_addr(48'hFE_FA_F6_F2_EE_EB, "R7 last byte bit0");
        idle(1, "R9 close");

        // R9: select dropped mid-frame after a mismatch, then a fresh frame
        drive(1'b1, 1'b1, 3'd0, 8'h00, "R5 early mismatch");
        drive(1'b1, 1'b1, 3'd1, 8'hFA, "R5 still low");
        drive(1'b0, 1'b0, 3'd0, 8'h00, "R9 mid-frame release");
        send_addr(48'hFE_FA_F6_F2_EE_EA, "R9 fresh frame own");
        idle(2, "R9 close");

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule